// File: doc/BRIEF.md
# ISA Plug and Play Card Isolation Controller

This block is the card-side logic of the ISA Plug and Play configuration protocol. After reset it is dormant. It watches every byte written to the shared address port and waits for a 32-byte initiation key. Once the whole key has arrived without a break, the card starts to respond. Writes to the address port then pick one of the standard configuration registers, and writes to the data port act on that register.

The host uses the wake command to move the card through the sleep, isolation and config states. In isolation the host reads the card's 72-bit identity one bit at a time, and each bit comes as a pair of reads. The host then gives the card a select number, reads its resource table, and programs an I/O base, an IRQ line and the activate flag.

The identity is eight fixed bytes followed by a checksum byte. An LFSR folds the first eight bytes into that checksum. The resource bytes come after the checksum. The identity and the resource bytes are parameters, so the block itself holds no table contents.

Top module: `pnp_iso_ctrl`

## Requirements
- R1: After reset the state output is wait-for-key (encoding 0: wait-for-key 0, sleep 1, isolation 2, config 3). The activate flag, select number, I/O base, IRQ and read-port outputs are all zero.
- R2: In wait-for-key, each address-port byte is compared with key entry N. The key starts at 0x6A and each next entry is {k[0]^k[1], k[7:1]}. A match advances N. Any wrong byte sends N back to 0. The 32nd consecutive match enters sleep.
- R3: In wait-for-key an address-port write does not change the selected register. In every other state it sets the selected register index.
- R4: A data write to register 0x00 sets the read-port output to {value, 2'b11}.
- R5: A data write to register 0x03 works on the select number. A value of 0, when the select number is 0, clears the serial counter and enters isolation. A nonzero value equal to the select number enters config. Any other nonzero value enters sleep.
- R6: A data write to register 0x06 in isolation stores the select number and enters config. The same write in any other state has no effect.
- R7: A data write to register 0x02 with bit 1 set returns to wait-for-key. Bit 2 clears the select number unless the state is wait-for-key.
- R8: A data write to register 0x30 sets the activate flag from bit 0. Register 0x60 sets the high byte of the I/O base and register 0x61 the low byte. Register 0x70 sets the IRQ from bits 3:0.
- R9: A read of register 0x01 splits the serial counter into fields: step = bit 0, bit index = bits 3:1, byte offset = bits 11:4. Inside the table it returns 0x55 on step 0 or 0xAA on step 1 when that bit is set, and 0x00 when it is clear, then adds 1 to the counter. Past the table end it returns 0x00 and leaves the counter alone.
- R10: Table byte 8 is the checksum. Start from 0x6A and feed identity bytes 0 to 7, LSB first. Each step computes c = {c[0]^c[1]^bit, c[7:1]}.
- R11: A read of register 0x04 inside the table returns the byte at the counter's byte offset and adds 16 to the counter; past the end it returns 0x00. Register 0x05 always reads 0x01, and any other register reads 0x00.
- R12: Completing the key, or a zero wake that enters isolation, clears the activate flag and the serial counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_wr_i | input | 1 | Single-cycle strobe: write to the address port |
| data_wr_i | input | 1 | Single-cycle strobe: write to the data port |
| rd_i | input | 1 | Single-cycle strobe: read from the read-data port |
| wdata_i | input | 8 | Write data for either port |
| rdata_o | output | 8 | Read data for the selected register, valid while rd_i is high |
| rd_port_o | output | 10 | Programmed read-data port address |
| csn_o | output | 8 | Card select number |
| state_o | output | 2 | Protocol state |
| io_base_o | output | 16 | Programmed I/O base |
| irq_o | output | 4 | Programmed IRQ number |
| active_o | output | 1 | Activate flag |

## Verification
The bench targets the key restart after a stray byte. A design that kept its place in the key would wake the card after only 31 good bytes. The bench also walks the whole isolation readout and reads past the table end. A wrong field split in the counter would scramble the 0x55/0xAA pairs, and a counter that kept advancing past the end would make the resource reads land on the wrong bytes. The checksum byte is compared against a value the bench computes on its own, so a wrong shift direction or a wrong seed shows up as a bad byte 8. A card that took the select number outside isolation, or whose address writes leaked through while it waited for the key, would show a changed select number or a changed activate flag.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } pnp_state_e;

  localparam logic [7:0] REG_RDPORT = 8'h00;
  localparam logic [7:0] REG_SERIAL = 8'h01;
  localparam logic [7:0] REG_CFGCTL = 8'h02;
  localparam logic [7:0] REG_WAKE   = 8'h03;
  localparam logic [7:0] REG_RES    = 8'h04;
  localparam logic [7:0] REG_STATUS = 8'h05;
  localparam logic [7:0] REG_CSN    = 8'h06;
  localparam logic [7:0] REG_ACT    = 8'h30;
  localparam logic [7:0] REG_IOHI   = 8'h60;
  localparam logic [7:0] REG_IOLO   = 8'h61;
  localparam logic [7:0] REG_IRQ    = 8'h70;

  localparam logic [7:0] CSUM_SEED  = 8'h6A;

  function automatic logic [7:0] key_next(input logic [7:0] c);
    return {c[0] ^ c[1], c[7:1]};
  endfunction

endpackage

// File: rtl/pnp_key_detect.sv
module pnp_key_detect
  import pnp_pkg::*;
#(
  parameter logic [7:0] SEED    = 8'h6A,
  parameter int         KEY_LEN = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  input  logic       clear_i,
  output logic       done_o
);

  localparam int IDX_W = $clog2(KEY_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

  logic [7:0]       exp_q;
  logic [IDX_W-1:0] idx_q;
  logic             hit, miss;

  assign hit    = arm_i && wr_i && (data_i == exp_q);
  assign miss   = arm_i && wr_i && (data_i != exp_q);
  assign done_o = hit && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= SEED;
      idx_q <= '0;
    end else if (clear_i || miss || done_o) begin
      exp_q <= SEED;
      idx_q <= '0;
    end else if (hit) begin
      exp_q <= key_next(exp_q);
      idx_q <= idx_q + 1'b1;
    end
  end

  // R2: key position moves only on an armed address write or a clear
  a_r2_idx_moves_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != $past(idx_q)) |-> ($past(arm_i && wr_i) || $past(clear_i)));

  // R2: key position back at the start after a wrong byte
  a_r2_miss_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && wr_i && !clear_i && (data_i != exp_q)) |=> (idx_q == '0) && (exp_q == SEED));

endmodule

// File: rtl/pnp_id_rom.sv
module pnp_id_rom
  import pnp_pkg::*;
#(
  parameter logic [63:0]          ID_BYTES  = 64'h07000001_80124E25,
  parameter int                   RES_LEN   = 4,
  parameter logic [8*RES_LEN-1:0] RES_BYTES = 32'h7915100A
) (
  input  logic [7:0] offset_i,
  output logic [7:0] byte_o,
  output logic       in_range_o
);

  localparam int ID_LEN  = 8;
  localparam int TBL_LEN = ID_LEN + 1 + RES_LEN;
  localparam int IDX_W   = $clog2(TBL_LEN);

  function automatic logic [7:0] id_csum(input logic [63:0] id);
    logic [7:0] c;
    c = CSUM_SEED;
    for (int i = 0; i < 64; i++) c = {c[0] ^ c[1] ^ id[i], c[7:1]};
    return c;
  endfunction

  localparam logic [7:0] CSUM = id_csum(ID_BYTES);

  logic [7:0] tbl [TBL_LEN];

  for (genvar g = 0; g < TBL_LEN; g++) begin : g_tbl
    if (g < ID_LEN) begin : g_id
      assign tbl[g] = ID_BYTES[8*g +: 8];
    end else if (g == ID_LEN) begin : g_csum
      assign tbl[g] = CSUM;
    end else begin : g_res
      assign tbl[g] = RES_BYTES[8*(g-ID_LEN-1) +: 8];
    end
  end

  assign in_range_o = (int'(offset_i) < TBL_LEN);
  assign byte_o     = in_range_o ? tbl[offset_i[IDX_W-1:0]] : 8'h00;

endmodule

// File: rtl/pnp_iso_ctrl.sv
module pnp_iso_ctrl
  import pnp_pkg::*;
#(
  parameter logic [7:0]           KEY_SEED  = 8'h6A,
  parameter int                   KEY_LEN   = 32,
  parameter logic [63:0]          ID_BYTES  = 64'h07000001_80124E25,
  parameter int                   RES_LEN   = 4,
  parameter logic [8*RES_LEN-1:0] RES_BYTES = 32'h7915100A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        addr_wr_i,
  input  logic        data_wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [9:0]  rd_port_o,
  output logic [7:0]  csn_o,
  output logic [1:0]  state_o,
  output logic [15:0] io_base_o,
  output logic [3:0]  irq_o,
  output logic        active_o
);

  localparam int STEP_W = 1;
  localparam int BIT_W  = 3;
  localparam int OFF_W  = 8;
  localparam int CNT_W  = STEP_W + BIT_W + OFF_W;
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(1) << (STEP_W + BIT_W);

  pnp_state_e       state_q;
  logic [7:0]       addr_q, csn_q;
  logic [9:0]       rdp_q;
  logic [15:0]      io_q;
  logic [3:0]       irq_q;
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;

  logic             key_done, key_clear;
  logic [7:0]       tbl_byte;
  logic             in_range;
  logic             ser_step;
  logic [BIT_W-1:0] ser_bit;
  logic [OFF_W-1:0] ser_off;

  assign ser_step = cnt_q[0];
  assign ser_bit  = cnt_q[STEP_W +: BIT_W];
  assign ser_off  = cnt_q[STEP_W+BIT_W +: OFF_W];

  assign key_clear = data_wr_i && (addr_q == REG_CFGCTL) && wdata_i[1];

  pnp_key_detect #(
    .SEED    (KEY_SEED),
    .KEY_LEN (KEY_LEN)
  ) i_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (state_q == ST_WAIT_KEY),
    .wr_i    (addr_wr_i),
    .data_i  (wdata_i),
    .clear_i (key_clear),
    .done_o  (key_done)
  );

  pnp_id_rom #(
    .ID_BYTES  (ID_BYTES),
    .RES_LEN   (RES_LEN),
    .RES_BYTES (RES_BYTES)
  ) i_rom (
    .offset_i   (ser_off),
    .byte_o     (tbl_byte),
    .in_range_o (in_range)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_KEY;
      addr_q  <= '0;
      csn_q   <= '0;
      rdp_q   <= '0;
      io_q    <= '0;
      irq_q   <= '0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (key_done) begin
        state_q <= ST_SLEEP;
        cnt_q   <= '0;
        act_q   <= 1'b0;
      end
      if (addr_wr_i && state_q != ST_WAIT_KEY) addr_q <= wdata_i;
      if (data_wr_i) begin
        unique case (addr_q)
          REG_RDPORT: rdp_q <= {wdata_i, 2'b11};
          REG_CFGCTL: begin
            if (wdata_i[2] && state_q != ST_WAIT_KEY) csn_q <= '0;
            if (wdata_i[1]) state_q <= ST_WAIT_KEY;
          end
          REG_WAKE: begin
            if (wdata_i == '0) begin
              if (csn_q == '0) begin
                cnt_q   <= '0;
                act_q   <= 1'b0;
                state_q <= ST_ISOLATE;
              end
            end else if (wdata_i == csn_q) begin
              state_q <= ST_CONFIG;
            end else begin
              state_q <= ST_SLEEP;
            end
          end
          REG_CSN: begin
            if (state_q == ST_ISOLATE) begin
              csn_q   <= wdata_i;
              state_q <= ST_CONFIG;
            end
          end
          REG_ACT:  act_q       <= wdata_i[0];
          REG_IOHI: io_q[15:8]  <= wdata_i;
          REG_IOLO: io_q[7:0]   <= wdata_i;
          REG_IRQ:  irq_q       <= wdata_i[3:0];
          default: ;
        endcase
      end else if (rd_i && in_range) begin
        if (addr_q == REG_SERIAL)   cnt_q <= cnt_q + CNT_W'(1);
        else if (addr_q == REG_RES) cnt_q <= cnt_q + CNT_BYTE;
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    unique case (addr_q)
      REG_SERIAL: if (tbl_byte[ser_bit]) rdata_o = ser_step ? 8'hAA : 8'h55;
      REG_RES:    rdata_o = tbl_byte;
      REG_STATUS: rdata_o = 8'h01;
      default: ;
    endcase
  end

  assign rd_port_o = rdp_q;
  assign csn_o     = csn_q;
  assign state_o   = state_q;
  assign io_base_o = io_q;
  assign irq_o     = irq_q;
  assign active_o  = act_q;

  // R2: finishing the key lands in sleep
  a_r2_key_to_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_done && !data_wr_i) |=> (state_q == ST_SLEEP));

  // R6: a new nonzero select number is only taken from isolation
  a_r6_csn_from_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csn_q != $past(csn_q)) && (csn_q != '0)) |-> ($past(state_q) == ST_ISOLATE));

  // R5: isolation is always entered with a fresh serial counter
  a_r5_iso_entry_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ISOLATE) && ($past(state_q) != ST_ISOLATE)) |-> (cnt_q == '0));

  // R9: an in-range serial read moves the counter by exactly one
  a_r9_serial_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !data_wr_i && !key_done && in_range && addr_q == REG_SERIAL)
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R8: IRQ changes only through its own register
  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q != $past(irq_q)) |-> $past(data_wr_i && addr_q == REG_IRQ));

endmodule

// File: tb/test_pnp_iso_ctrl.sv
module test_pnp_iso_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 1'b0, data_wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [9:0]  rd_port;
  logic [7:0]  csn;
  logic [1:0]  state;
  logic [15:0] io_base;
  logic [3:0]  irq;
  logic        active;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pnp_iso_ctrl i_pnp_iso_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_wr_i(addr_wr), .data_wr_i(data_wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rd_port_o(rd_port), .csn_o(csn), .state_o(state),
    .io_base_o(io_base), .irq_o(irq), .active_o(active)
  );

  localparam int TBL_N = 13;
  logic [7:0] tbl [TBL_N];

  // {op, req, value, expected}: op 0 addr write, 1 data write, 2 read, 3 state check
  localparam int NV = 39;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 4'd4,  8'h00, 8'h00}, {2'd1, 4'd4,  8'h80, 8'h00},                               // R4
    {2'd0, 4'd6,  8'h06, 8'h00}, {2'd1, 4'd6,  8'h05, 8'h00}, {2'd3, 4'd6,  8'h00, 8'h01}, // R6 ignored in sleep
    {2'd0, 4'd5,  8'h03, 8'h00}, {2'd1, 4'd5,  8'h00, 8'h00}, {2'd3, 4'd5,  8'h00, 8'h02}, // R5 zero wake
    {2'd0, 4'd11, 8'h05, 8'h00}, {2'd2, 4'd11, 8'h00, 8'h01},                               // R11 status
    {2'd0, 4'd11, 8'h07, 8'h00}, {2'd2, 4'd11, 8'h00, 8'h00},                               // R11 other
    {2'd0, 4'd11, 8'h04, 8'h00}, {2'd2, 4'd11, 8'h00, 8'h25}, {2'd2, 4'd11, 8'h00, 8'h4E}, // R11 resource
    {2'd0, 4'd9,  8'h01, 8'h00}, {2'd2, 4'd9,  8'h00, 8'h00}, {2'd2, 4'd9,  8'h00, 8'h00}, // R9 byte 2 bit 0
    {2'd2, 4'd9,  8'h00, 8'h55}, {2'd2, 4'd9,  8'h00, 8'hAA},                               // R9 byte 2 bit 1
    {2'd0, 4'd6,  8'h06, 8'h00}, {2'd1, 4'd6,  8'h05, 8'h00}, {2'd3, 4'd6,  8'h00, 8'h03}, // R6
    {2'd0, 4'd5,  8'h03, 8'h00}, {2'd1, 4'd5,  8'h07, 8'h00}, {2'd3, 4'd5,  8'h00, 8'h01}, // R5 other csn
    {2'd1, 4'd5,  8'h05, 8'h00}, {2'd3, 4'd5,  8'h00, 8'h03},                               // R5 own csn
    {2'd0, 4'd6,  8'h06, 8'h00}, {2'd1, 4'd6,  8'h09, 8'h00}, {2'd3, 4'd6,  8'h00, 8'h03}, // R6 ignored in config
    {2'd0, 4'd8,  8'h30, 8'h00}, {2'd1, 4'd8,  8'h01, 8'h00},                               // R8
    {2'd0, 4'd8,  8'h60, 8'h00}, {2'd1, 4'd8,  8'h03, 8'h00},
    {2'd0, 4'd8,  8'h61, 8'h00}, {2'd1, 4'd8,  8'h40, 8'h00},
    {2'd0, 4'd8,  8'h70, 8'h00}, {2'd1, 4'd8,  8'hFB, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [7:0] v);
    @(negedge clk); wdata = v; addr_wr = 1'b1;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); wdata = v; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] v);
    @(negedge clk); rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // sends key entries first..last
  task automatic send_key(input int first, input int last);
    logic [7:0] k;
    k = 8'h6A;
    for (int i = 0; i <= last; i++) begin
      if (i >= first) wr_addr(k);
      k = {k[0] ^ k[1], k[7:1]};
    end
  endtask

  initial begin
    logic [7:0] v, c;
    logic [63:0] id;
    id = 64'h07000001_80124E25;
    for (int i = 0; i < 8; i++) tbl[i] = id[8*i +: 8];
    c = 8'h6A;
    for (int i = 0; i < 64; i++) c = {c[0] ^ c[1] ^ id[i], c[7:1]};
    tbl[8] = c; tbl[9] = 8'h0A; tbl[10] = 8'h10; tbl[11] = 8'h15; tbl[12] = 8'h79;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", 32'(state), 0);
    chk("R1 active", 32'(active), 0);
    chk("R1 csn", 32'(csn), 0);
    chk("R1 io", 32'(io_base), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdport", 32'(rd_port), 0);

    // R2: 31 entries do not wake, the 32nd does
    send_key(0, 30);
    chk("R2 partial key", 32'(state), 0);
    send_key(31, 31);
    chk("R2 full key", 32'(state), 1);

    for (int n = 0; n < NV; n++) begin
      logic [21:0] e;
      e = VEC[n];
      case (e[21:20])
        2'd0: wr_addr(e[15:8]);
        2'd1: wr_data(e[15:8]);
        2'd2: begin rd_byte(v); chk($sformatf("R%0d read #%0d", e[19:16], n), 32'(v), 32'(e[7:0])); end
        default: chk($sformatf("R%0d state #%0d", e[19:16], n), 32'(state), 32'(e[7:0]));
      endcase
    end
    chk("R4 rdport", 32'(rd_port), 32'h203);
    chk("R6 csn kept", 32'(csn), 5);
    chk("R8 active", 32'(active), 1);
    chk("R8 io base", 32'(io_base), 32'h0340);
    chk("R8 irq", 32'(irq), 32'hB);

    // R7: clear csn in config, then back to wait-for-key
    wr_addr(8'h02); wr_data(8'h04);
    chk("R7 csn cleared", 32'(csn), 0);
    chk("R7 state kept", 32'(state), 3);
    wr_data(8'h02);
    chk("R7 wait-for-key", 32'(state), 0);
    // R3: address writes in wait-for-key do not select a register
    wr_addr(8'h30); wr_data(8'h00);
    chk("R3 active untouched", 32'(active), 1);
    chk("R3 state", 32'(state), 0);

    // R2: a wrong byte restarts matching
    send_key(0, 9);
    wr_addr(8'h00);
    send_key(0, 30);
    chk("R2 restart needs full key", 32'(state), 0);
    send_key(31, 31);
    chk("R2 key after restart", 32'(state), 1);
    chk("R12 key clears active", 32'(active), 0);

    // R9: full isolation readout
    wr_addr(8'h03); wr_data(8'h00);
    chk("R5 isolation", 32'(state), 2);
    wr_addr(8'h01);
    for (int b = 0; b < TBL_N; b++)
      for (int j = 0; j < 8; j++) begin
        rd_byte(v); chk("R9 step0", 32'(v), tbl[b][j] ? 32'h55 : 32'h00);
        rd_byte(v); chk("R9 step1", 32'(v), tbl[b][j] ? 32'hAA : 32'h00);
      end
    rd_byte(v); chk("R9 past end", 32'(v), 0);
    rd_byte(v); chk("R9 past end again", 32'(v), 0);
    wr_addr(8'h04);
    rd_byte(v); chk("R11 counter held past end", 32'(v), 0);

    // R10 / R11: resource readout including checksum
    wr_addr(8'h03); wr_data(8'h00);
    wr_addr(8'h04);
    for (int b = 0; b < TBL_N; b++) begin
      rd_byte(v);
      chk(b == 8 ? "R10 checksum" : "R11 table byte", 32'(v), 32'(tbl[b]));
    end
    rd_byte(v); chk("R11 past end", 32'(v), 0);

    // R12: zero wake clears activate
    wr_addr(8'h30); wr_data(8'h01);
    chk("R8 active in isolation", 32'(active), 1);
    wr_addr(8'h03); wr_data(8'h00);
    chk("R12 wake clears active", 32'(active), 0);
    chk("R12 state", 32'(state), 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule